// File: doc/BRIEF.md
# Idle and Standby Mode Controller

This block runs the power-state handshakes of a single peripheral. On its target side it decides when a system request to go idle is acknowledged. On its initiator side it decides when the peripheral's local bus master is placed in standby, and it gates that master's permission to start transactions.

Each side follows one of three policies, held in a 32-bit configuration word reached through a simple register bus. A forced policy obeys the system, or forces standby, regardless of what the peripheral is doing. A never policy keeps the side permanently active. A conditional policy weighs internal activity. A conditional idle acknowledge is withheld while the target is still busy, and it is dropped again as soon as new activity appears.

The configuration word sits at byte offset 0x54 and is written with full 32-bit accesses. The register bus is a plain strobe interface with no back-pressure: a write completes in the cycle its strobe is high, and read data is returned combinationally while the read strobe is high.

Top module: `pm_ctrl`

## Requirements
- R1: After reset the configuration word reads 0, the idle acknowledge is low, standby status is high and the transaction permit is low.
- R2: In the word at offset 0x54, bits 5:4 (standby policy) and 3:2 (idle policy) are stored. Bits 1:0 are stored but have no effect. Bits 31:6 always read as zero, even after a write of all ones.
- R3: A write to any other offset leaves the word unchanged. A read of any other offset, or any cycle with the read strobe low, returns zero.
- R4: With idle policy 0 (forced), the idle acknowledge equals the idle request of the previous clock, whatever the busy input.
- R5: With idle policy 1 (never), the idle acknowledge is low one clock later and stays low.
- R6: With idle policy 2 (conditional), the acknowledge is high one clock after a cycle where the request is high and busy is low. It is low one clock after a cycle where the request is low or busy is high.
- R7: Idle policy 3 behaves exactly as idle policy 0.
- R8: With standby policy 0 (forced), standby status is high one clock later.
- R9: With standby policy 1 (never), standby status is low one clock later.
- R10: With standby policy 2 (conditional), standby status equals the inverse of the initiator-need input of the previous clock.
- R11: Standby policy 3 behaves exactly as standby policy 0.
- R12: The transaction permit is always the inverse of standby status, so it is already low in the first cycle standby is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, zero when not reading the configuration word |
| idle_req | input | 1 | System request for the target to go idle |
| tgt_busy | input | 1 | Target still has work to serve |
| init_need | input | 1 | Peripheral needs its bus master |
| idle_ack | output | 1 | Registered idle acknowledge |
| standby | output | 1 | Registered initiator standby status |
| init_permit | output | 1 | Initiator may start a transaction |

## Verification
On every cycle, assertions check the one-clock relation between each policy and its output. Forced idle must track the request, and the never policies must hold their outputs inactive. A conditional acknowledge must drop after busy, conditional standby must track the inverse of need, and a write to the configuration offset must be captured. Only the bench scenarios can show the register map as a whole: masking of the upper bits, ignored offsets, the aliasing of the reserved encodings onto forced behaviour, and a full drain sequence in which the acknowledge is withheld, granted and then revoked.

// File: rtl/pm_ctrl_pkg.sv
package pm_ctrl_pkg;

  typedef enum logic [1:0] {
    POL_FORCE = 2'd0,
    POL_NEVER = 2'd1,
    POL_COND  = 2'd2,
    POL_RSVD  = 2'd3
  } pol_e;

  typedef struct packed {
    logic [1:0] sby_pol;
    logic [1:0] idle_pol;
    logic [1:0] spare;
  } cfg_t;

  // reserved encoding collapses onto the reset (forced) policy
  function automatic pol_e norm_pol(input logic [1:0] raw);
    pol_e p;
    p = pol_e'(raw);
    if (p == POL_RSVD) p = POL_FORCE;
    return p;
  endfunction

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
  import pm_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg
);

  localparam int FIELD_W = $bits(cfg_t);
  localparam int PAD_W   = DATA_W - FIELD_W;

  logic hit;
  assign hit = (addr == CFG_OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg <= '0;
    else if (wr_en && hit) cfg <= cfg_t'(wdata[FIELD_W-1:0]);
  end

  always_comb begin
    rdata = '0;
    if (rd_en && hit) rdata = {{PAD_W{1'b0}}, cfg};
  end

  // R2
  cfg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit) |=> (cfg == $past(wdata[FIELD_W-1:0])));

  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && hit) |=> $stable(cfg));

endmodule

// File: rtl/pm_idle_fsm.sv
module pm_idle_fsm
  import pm_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pol_raw,
  input  logic       idle_req,
  input  logic       tgt_busy,
  output logic       idle_ack
);

  pol_e pol;
  logic ack_nxt;

  assign pol = norm_pol(pol_raw);

  always_comb begin
    unique case (pol)
      POL_NEVER: ack_nxt = 1'b0;
      POL_COND:  ack_nxt = idle_req && !tgt_busy;
      default:   ack_nxt = idle_req;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle_ack <= 1'b0;
    else        idle_ack <= ack_nxt;
  end

  // R4
  idle_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_raw == 2'd0) |=> (idle_ack == $past(idle_req)));

  // R5
  idle_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_raw == 2'd1) |=> !idle_ack);

  // R6
  idle_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_raw == 2'd2 && tgt_busy) |=> !idle_ack);

endmodule

// File: rtl/pm_standby_fsm.sv
module pm_standby_fsm
  import pm_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pol_raw,
  input  logic       init_need,
  output logic       standby,
  output logic       permit
);

  pol_e pol;
  logic sby_nxt;

  assign pol = norm_pol(pol_raw);

  always_comb begin
    unique case (pol)
      POL_NEVER: sby_nxt = 1'b0;
      POL_COND:  sby_nxt = !init_need;
      default:   sby_nxt = 1'b1;
    endcase
  end

  // reset policy is forced, so the master starts in standby
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) standby <= 1'b1;
    else        standby <= sby_nxt;
  end

  assign permit = !standby;

  // R9
  sby_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_raw == 2'd1) |=> !standby);

  // R10
  sby_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_raw == 2'd2) |=> (standby == !$past(init_need)));

  // R8
  sby_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_raw == 2'd0) |=> standby);

endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CFG_OFFSET = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              idle_req,
  input  logic              tgt_busy,
  input  logic              init_need,
  output logic              idle_ack,
  output logic              standby,
  output logic              init_permit
);

  cfg_t cfg;

  pm_cfg_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_OFFSET(CFG_OFFSET)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .rd_en(reg_rd_en), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  pm_idle_fsm u_idle (
    .clk(clk), .rst_n(rst_n), .pol_raw(cfg.idle_pol),
    .idle_req(idle_req), .tgt_busy(tgt_busy), .idle_ack(idle_ack)
  );

  pm_standby_fsm u_sby (
    .clk(clk), .rst_n(rst_n), .pol_raw(cfg.sby_pol),
    .init_need(init_need), .standby(standby), .permit(init_permit)
  );

endmodule

// File: tb/test_pm_ctrl.sv
module test_pm_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        idle_req = 1'b0, tgt_busy = 1'b0, init_need = 1'b0;
  logic        idle_ack, standby, init_permit;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pm_ctrl i_pm_ctrl (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .idle_req(idle_req), .tgt_busy(tgt_busy), .init_need(init_need),
    .idle_ack(idle_ack), .standby(standby), .init_permit(init_permit)
  );

  // {idle_pol, sby_pol, req, busy, need, exp_ack, exp_sby}
  localparam int NV = 10;
  localparam logic [8:0] VEC [NV] = '{
    {2'd0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},  // R4 R8
    {2'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},  // R4 R8
    {2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 R9
    {2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 R9
    {2'd2, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // R6 R10
    {2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},  // R6 R10
    {2'd2, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 R10
    {2'd3, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},  // R7 R11
    {2'd3, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // R7 R11
    {2'd0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}   // R4 R9
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    reg_rd_en = 1'b0;
  endtask

  // drive inputs at a falling edge, sample after the next rising edge
  task automatic step(input logic r, input logic b, input logic n);
    @(negedge clk);
    idle_req = r; tgt_busy = b; init_need = n;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ack", {31'b0, idle_ack}, 32'd0);
    chk("R1 standby", {31'b0, standby}, 32'd1);
    chk("R1 permit", {31'b0, init_permit}, 32'd0);
    rst_n = 1'b1;
    rd(8'h54, d);
    chk("R1 cfg", d, 32'd0);

    foreach (VEC[i]) begin
      wr(8'h54, {26'b0, VEC[i][6:5], VEC[i][8:7], 2'b00});
      step(VEC[i][4], VEC[i][3], VEC[i][2]);
      chk($sformatf("R4-R11 vec%0d ack", i), {31'b0, idle_ack}, {31'b0, VEC[i][1]});
      chk($sformatf("R8-R11 vec%0d sby", i), {31'b0, standby}, {31'b0, VEC[i][0]});
      chk($sformatf("R12 vec%0d permit", i), {31'b0, init_permit}, {31'b0, !VEC[i][0]});
    end

    // R2 upper bits masked, spare bits stored
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, d);
    chk("R2 mask", d, 32'h0000_003F);
    // R3 other offset ignored, read zero
    wr(8'h50, 32'h0000_0000);
    rd(8'h54, d);
    chk("R3 stray write", d, 32'h0000_003F);
    rd(8'h50, d);
    chk("R3 stray read", d, 32'd0);
    @(negedge clk);
    #1 chk("R3 no strobe", reg_rdata, 32'd0);

    // R6 drain sequence in conditional idle, R10 standby tracking
    wr(8'h54, 32'h0000_0028);
    step(1'b1, 1'b1, 1'b1);
    chk("R6 withheld", {31'b0, idle_ack}, 32'd0);
    chk("R10 need", {31'b0, standby}, 32'd0);
    step(1'b1, 1'b0, 1'b0);
    chk("R6 granted", {31'b0, idle_ack}, 32'd1);
    chk("R12 permit low", {31'b0, init_permit}, 32'd0);
    step(1'b1, 1'b1, 1'b0);
    chk("R6 revoked", {31'b0, idle_ack}, 32'd0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    chk("R6 req drop", {31'b0, idle_ack}, 32'd0);

    // R5 never mode holds ack low over several cycles
    wr(8'h54, 32'h0000_0004);
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    chk("R5 hold", {31'b0, idle_ack}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule